// File: doc/BRIEF.md
# Stack-to-Register Micro-op Translator

This block is the front end of a processor that runs stack-form code on an out-of-order register back end. It keeps a stack of register tags. Each tag names the physical register that will hold one value on the program's operand stack. Each incoming stack instruction pops the tags of its operands off that stack, and those tags become its source fields. When the instruction produces a value, it takes a fresh register from a free pool and pushes that register's tag. The back end therefore sees ordinary register micro-ops whose dependencies were found from stack position alone.

Up to four instructions arrive per clock on four lanes. They are translated in program order, and each lane sees the stack and the free pool as the earlier lanes left them. Translation stops at the first lane that cannot proceed, for one of three reasons: its operands are missing, the tag stack would exceed its depth, or no register is free. The number of lanes consumed is reported back to the source. A load that reads an address stored to earlier in the same group is flagged with the lane of that store, so that the back end orders the two. Translated groups leave through a registered stage with a valid/ready handshake. The back end hands registers back to the pool with a release strobe.

Top module: `sx_translator`

## Requirements
- R1: After reset the tag stack is empty, all 32 registers are free and out_valid is 0.
- R2: A load (op code 0) takes no source and allocates the lowest-numbered free register as its destination. It pushes that tag and carries its address in uop_addr.
- R3: Add (op code 3) and subtract (op code 4) pop two tags. src0 is the tag that was second from the top and src1 the tag that was on top. The new destination tag is pushed.
- R4: A store (op code 1) pops one tag into src0, has no destination, pushes nothing and carries its address.
- R5: Negate (op code 2) uses the top tag as src0 and replaces it with its new destination tag, so the depth is unchanged.
- R6: Pop (op code 5) removes the top tag and emits no micro-op. Codes 6 and 7 are consumed with no stack effect and no micro-op. A group that emits no micro-op leaves out_valid at 0.
- R7: Lanes are taken in order 0..3, and each lane sees the stack and pool state left by the lanes before it. Taking stops at the first lane whose in_valid is 0. in_take gives the number of lanes consumed (0 to 4).
- R8: A lane whose pop count exceeds the current depth is not taken and no later lane is taken either. err_underflow is 1 in that cycle, and the lanes before it are still taken.
- R9: The tag stack holds 16 entries. A lane that would raise the depth above 16 is not taken.
- R10: A lane that needs a destination while no register is free is not taken. A release strobe returns the given tag to the pool, where it can be allocated from the next cycle on.
- R11: A load whose address equals that of a store taken in an earlier lane of the same group sets uop_mem_dep. uop_dep_lane gives the nearest such store lane (2 bits per lane).
- R12: While out_valid is 1 and out_ready is 0, the output fields hold and in_take is 0.
- R13: An output lane is valid only if its input lane was taken and emitted a micro-op. Every field of any other lane is 0. uop_class equals the op code. uop_addr is 0 for non-memory micro-ops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 4 | Per-lane instruction present |
| in_op | input | 12 | 3-bit op code per lane |
| in_addr | input | 128 | 32-bit memory address per lane |
| in_take | output | 3 | Lanes consumed this cycle |
| err_underflow | output | 1 | The first blocked lane lacked operands |
| rel_valid | input | 1 | Release strobe |
| rel_tag | input | 5 | Register returned to the pool |
| out_valid | output | 1 | Translated group present |
| out_ready | input | 1 | Back end accepts the group |
| uop_valid | output | 4 | Per-lane micro-op present |
| uop_class | output | 12 | 3-bit class per lane |
| uop_src0 | output | 20 | First source tag per lane |
| uop_src0_v | output | 4 | First source used |
| uop_src1 | output | 20 | Second source tag per lane |
| uop_src1_v | output | 4 | Second source used |
| uop_dst | output | 20 | Destination tag per lane |
| uop_dst_v | output | 4 | Destination used |
| uop_addr | output | 128 | Address per lane |
| uop_mem_dep | output | 4 | Load ordered behind an earlier store |
| uop_dep_lane | output | 8 | Lane of that store |

## Verification
A stack entry that holds the wrong tag shows up at the source fields of the very next micro-op that pops it. That can be several groups after the fault, once the value is finally consumed. A fault in the stack pointer or the free mask shows much sooner, in the cycle's in_take and err_underflow or in the next destination tag, because both depend on depth and free state at once. The bench runs a queue-based model alongside the design and compares every output field on every clock. Any divergence is therefore caught in the cycle where it first reaches a port, not only at the end of a sequence.

// File: rtl/sx_pkg.sv
package sx_pkg;

  typedef enum logic [2:0] {
    OP_LOAD  = 3'd0,
    OP_STORE = 3'd1,
    OP_NEG   = 3'd2,
    OP_ADD   = 3'd3,
    OP_SUB   = 3'd4,
    OP_POP   = 3'd5,
    OP_RSV6  = 3'd6,
    OP_RSV7  = 3'd7
  } sx_op_e;

  // Stack effect of one op: tags popped, tags pushed, micro-op emitted,
  // destination register needed.
  function automatic void op_effect(input logic [2:0] op,
                                    output int npop, output int npush,
                                    output logic emit, output logic wdst);
    npop = 0; npush = 0; emit = 1'b0; wdst = 1'b0;
    case (op)
      OP_LOAD:        begin npop = 0; npush = 1; emit = 1'b1; wdst = 1'b1; end
      OP_STORE:       begin npop = 1; npush = 0; emit = 1'b1; wdst = 1'b0; end
      OP_NEG:         begin npop = 1; npush = 1; emit = 1'b1; wdst = 1'b1; end
      OP_ADD, OP_SUB: begin npop = 2; npush = 1; emit = 1'b1; wdst = 1'b1; end
      OP_POP:         begin npop = 1; npush = 0; emit = 1'b0; wdst = 1'b0; end
      default:        begin npop = 0; npush = 0; emit = 1'b0; wdst = 1'b0; end
    endcase
  endfunction

endpackage

// File: rtl/sx_free_pool.sv
module sx_free_pool #(
  parameter int NREG = 32,
  parameter int TW   = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            commit,
  input  logic [NREG-1:0] alloc_mask,
  input  logic            rel_valid,
  input  logic [TW-1:0]   rel_tag,
  output logic [NREG-1:0] free_q
);

  logic [NREG-1:0] free_d;

  always_comb begin
    free_d = free_q;
    if (commit) free_d = free_d & ~alloc_mask;
    if (rel_valid) free_d[rel_tag] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) free_q <= '1;
    else        free_q <= free_d;
  end

  // R10: only free registers are handed out
  p_alloc_free_r10: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> ((alloc_mask & ~free_q) == '0));

  // R10: a released register is free in the following cycle
  p_release_lands_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rel_valid |=> free_q[$past(rel_tag)]);

endmodule

// File: rtl/sx_tag_stack.sv
module sx_tag_stack #(
  parameter int DEPTH = 16,
  parameter int TW    = 5,
  parameter int SPW   = $clog2(DEPTH + 1)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      commit,
  input  logic [DEPTH-1:0][TW-1:0]  stk_d,
  input  logic [SPW-1:0]            sp_d,
  output logic [DEPTH-1:0][TW-1:0]  stk_q,
  output logic [SPW-1:0]            sp_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stk_q <= '0;
      sp_q  <= '0;
    end else if (commit) begin
      stk_q <= stk_d;
      sp_q  <= sp_d;
    end
  end

  // R9: depth never exceeds the stack size
  p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    sp_q <= SPW'(DEPTH));

  // R12: without a commit the depth holds
  p_depth_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(sp_q));

endmodule

// File: rtl/sx_group_xlate.sv
module sx_group_xlate
  import sx_pkg::*;
#(
  parameter int LANES = 4,
  parameter int NREG  = 32,
  parameter int DEPTH = 16,
  parameter int AW    = 32,
  parameter int TW    = $clog2(NREG),
  parameter int SPW   = $clog2(DEPTH + 1),
  parameter int IW    = $clog2(DEPTH),
  parameter int LIW   = (LANES > 1) ? $clog2(LANES) : 1,
  parameter int CW    = $clog2(LANES + 1)
) (
  input  logic                      slot_ok,
  input  logic [LANES-1:0]          in_valid,
  input  logic [LANES-1:0][2:0]     in_op,
  input  logic [LANES-1:0][AW-1:0]  in_addr,
  input  logic [DEPTH-1:0][TW-1:0]  stk_q,
  input  logic [SPW-1:0]            sp_q,
  input  logic [NREG-1:0]           free_q,
  output logic [CW-1:0]             take,
  output logic                      err_uf,
  output logic [DEPTH-1:0][TW-1:0]  stk_d,
  output logic [SPW-1:0]            sp_d,
  output logic [NREG-1:0]           alloc_mask,
  output logic [LANES-1:0]          l_v,
  output logic [LANES-1:0][2:0]     l_cls,
  output logic [LANES-1:0][TW-1:0]  l_s0,
  output logic [LANES-1:0]          l_s0v,
  output logic [LANES-1:0][TW-1:0]  l_s1,
  output logic [LANES-1:0]          l_s1v,
  output logic [LANES-1:0][TW-1:0]  l_dst,
  output logic [LANES-1:0]          l_dstv,
  output logic [LANES-1:0][AW-1:0]  l_addr,
  output logic [LANES-1:0]          l_md,
  output logic [LANES-1:0][LIW-1:0] l_mdl
);

  always_comb begin
    int sp, npop, npush, ltake;
    logic go, emit, wdst, found;
    logic [TW-1:0] pick, t_top, t_sec;
    logic [NREG-1:0] fm;
    logic [LANES-1:0] st_ok;

    stk_d = stk_q; sp = int'(sp_q); fm = free_q; alloc_mask = '0;
    go = slot_ok; ltake = 0; err_uf = 1'b0; st_ok = '0;
    l_v = '0; l_cls = '0; l_s0 = '0; l_s0v = '0; l_s1 = '0; l_s1v = '0;
    l_dst = '0; l_dstv = '0; l_addr = '0; l_md = '0; l_mdl = '0;

    for (int i = 0; i < LANES; i++) begin
      op_effect(in_op[i], npop, npush, emit, wdst);
      // lowest free register under the lanes already taken
      found = 1'b0; pick = '0;
      for (int r = NREG - 1; r >= 0; r--) begin
        if (fm[r]) begin found = 1'b1; pick = TW'(r); end
      end
      t_top = (sp >= 1) ? stk_d[IW'(sp - 1)] : '0;
      t_sec = (sp >= 2) ? stk_d[IW'(sp - 2)] : '0;

      if (go && in_valid[i]) begin
        if (npop > sp) begin
          go = 1'b0;
          err_uf = 1'b1;
        end else if (sp - npop + npush > DEPTH) begin
          go = 1'b0;
        end else if (wdst && !found) begin
          go = 1'b0;
        end else begin
          ltake = ltake + 1;
          sp = sp - npop;
          if (wdst) begin
            fm[pick] = 1'b0;
            alloc_mask[pick] = 1'b1;
            stk_d[IW'(sp)] = pick;
            sp = sp + 1;
          end
          if (emit) begin
            l_v[i]   = 1'b1;
            l_cls[i] = in_op[i];
            if (npop == 1) begin
              l_s0[i] = t_top; l_s0v[i] = 1'b1;
            end else if (npop == 2) begin
              l_s0[i] = t_sec; l_s0v[i] = 1'b1;
              l_s1[i] = t_top; l_s1v[i] = 1'b1;
            end
            if (wdst) begin
              l_dst[i] = pick; l_dstv[i] = 1'b1;
            end
            if (in_op[i] == OP_STORE) begin
              l_addr[i] = in_addr[i];
              st_ok[i]  = 1'b1;
            end
            if (in_op[i] == OP_LOAD) begin
              l_addr[i] = in_addr[i];
              for (int j = 0; j < LANES; j++) begin
                if (j < i && st_ok[j] && in_addr[j] == in_addr[i]) begin
                  l_md[i]  = 1'b1;
                  l_mdl[i] = LIW'(j);
                end
              end
            end
          end
        end
      end else begin
        go = 1'b0;
      end
    end

    sp_d = SPW'(sp);
    take = CW'(ltake);
  end

endmodule

// File: rtl/sx_translator.sv
module sx_translator
  import sx_pkg::*;
#(
  parameter int LANES = 4,
  parameter int NREG  = 32,
  parameter int DEPTH = 16,
  parameter int AW    = 32,
  localparam int TW   = $clog2(NREG),
  localparam int SPW  = $clog2(DEPTH + 1),
  localparam int IW   = $clog2(DEPTH),
  localparam int LIW  = (LANES > 1) ? $clog2(LANES) : 1,
  localparam int CW   = $clog2(LANES + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [LANES-1:0]     in_valid,
  input  logic [LANES*3-1:0]   in_op,
  input  logic [LANES*AW-1:0]  in_addr,
  output logic [CW-1:0]        in_take,
  output logic                 err_underflow,
  input  logic                 rel_valid,
  input  logic [TW-1:0]        rel_tag,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [LANES-1:0]     uop_valid,
  output logic [LANES*3-1:0]   uop_class,
  output logic [LANES*TW-1:0]  uop_src0,
  output logic [LANES-1:0]     uop_src0_v,
  output logic [LANES*TW-1:0]  uop_src1,
  output logic [LANES-1:0]     uop_src1_v,
  output logic [LANES*TW-1:0]  uop_dst,
  output logic [LANES-1:0]     uop_dst_v,
  output logic [LANES*AW-1:0]  uop_addr,
  output logic [LANES-1:0]     uop_mem_dep,
  output logic [LANES*LIW-1:0] uop_dep_lane
);

  typedef struct packed {
    logic           v;
    logic [2:0]     cls;
    logic [TW-1:0]  s0;
    logic           s0v;
    logic [TW-1:0]  s1;
    logic           s1v;
    logic [TW-1:0]  dst;
    logic           dstv;
    logic [AW-1:0]  addr;
    logic           md;
    logic [LIW-1:0] mdl;
  } rec_t;

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rs_q;
  logic       rst_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_s = rs_q[1];

  logic                      adv;
  logic [DEPTH-1:0][TW-1:0]  stk_q, stk_d;
  logic [SPW-1:0]            sp_q, sp_d;
  logic [NREG-1:0]           free_q, alloc_mask;
  logic [LANES-1:0]          l_v, l_s0v, l_s1v, l_dstv, l_md;
  logic [LANES-1:0][2:0]     l_cls;
  logic [LANES-1:0][TW-1:0]  l_s0, l_s1, l_dst;
  logic [LANES-1:0][AW-1:0]  l_addr;
  logic [LANES-1:0][LIW-1:0] l_mdl;
  logic [LANES-1:0][2:0]     op_v;
  logic [LANES-1:0][AW-1:0]  addr_v;

  rec_t [LANES-1:0] rec_d, rec_q;
  logic             ov_d, ov_q;

  assign op_v   = in_op;
  assign addr_v = in_addr;
  assign adv    = !ov_q || out_ready;

  sx_free_pool #(.NREG(NREG), .TW(TW)) u_pool (
    .clk(clk), .rst_n(rst_s), .commit(adv), .alloc_mask(alloc_mask),
    .rel_valid(rel_valid), .rel_tag(rel_tag), .free_q(free_q)
  );

  sx_tag_stack #(.DEPTH(DEPTH), .TW(TW), .SPW(SPW)) u_stack (
    .clk(clk), .rst_n(rst_s), .commit(adv), .stk_d(stk_d), .sp_d(sp_d),
    .stk_q(stk_q), .sp_q(sp_q)
  );

  sx_group_xlate #(
    .LANES(LANES), .NREG(NREG), .DEPTH(DEPTH), .AW(AW), .TW(TW),
    .SPW(SPW), .IW(IW), .LIW(LIW), .CW(CW)
  ) u_xlate (
    .slot_ok(adv), .in_valid(in_valid), .in_op(op_v), .in_addr(addr_v),
    .stk_q(stk_q), .sp_q(sp_q), .free_q(free_q),
    .take(in_take), .err_uf(err_underflow), .stk_d(stk_d), .sp_d(sp_d),
    .alloc_mask(alloc_mask), .l_v(l_v), .l_cls(l_cls), .l_s0(l_s0),
    .l_s0v(l_s0v), .l_s1(l_s1), .l_s1v(l_s1v), .l_dst(l_dst),
    .l_dstv(l_dstv), .l_addr(l_addr), .l_md(l_md), .l_mdl(l_mdl)
  );

  // next state of the output stage
  always_comb begin
    ov_d = |l_v;
    for (int i = 0; i < LANES; i++) begin
      rec_d[i].v    = l_v[i];
      rec_d[i].cls  = l_cls[i];
      rec_d[i].s0   = l_s0[i];
      rec_d[i].s0v  = l_s0v[i];
      rec_d[i].s1   = l_s1[i];
      rec_d[i].s1v  = l_s1v[i];
      rec_d[i].dst  = l_dst[i];
      rec_d[i].dstv = l_dstv[i];
      rec_d[i].addr = l_addr[i];
      rec_d[i].md   = l_md[i];
      rec_d[i].mdl  = l_mdl[i];
    end
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      ov_q  <= 1'b0;
      rec_q <= '0;
    end else if (adv) begin
      ov_q  <= ov_d;
      rec_q <= rec_d;
    end
  end

  assign out_valid = ov_q;
  always_comb begin
    for (int i = 0; i < LANES; i++) begin
      uop_valid[i]              = rec_q[i].v;
      uop_class[i*3 +: 3]       = rec_q[i].cls;
      uop_src0[i*TW +: TW]      = rec_q[i].s0;
      uop_src0_v[i]             = rec_q[i].s0v;
      uop_src1[i*TW +: TW]      = rec_q[i].s1;
      uop_src1_v[i]             = rec_q[i].s1v;
      uop_dst[i*TW +: TW]       = rec_q[i].dst;
      uop_dst_v[i]              = rec_q[i].dstv;
      uop_addr[i*AW +: AW]      = rec_q[i].addr;
      uop_mem_dep[i]            = rec_q[i].md;
      uop_dep_lane[i*LIW +: LIW] = rec_q[i].mdl;
    end
  end

  // R12: a stalled group holds its fields
  p_hold_r12: assert property (@(posedge clk) disable iff (!rst_s)
    (out_valid && !out_ready) |=> (out_valid && $stable(uop_valid) &&
      $stable(uop_dst) && $stable(uop_src0) && $stable(uop_addr)));

  // R12: nothing is consumed while the output stage is blocked
  p_no_take_blocked_r12: assert property (@(posedge clk) disable iff (!rst_s)
    (out_valid && !out_ready) |-> (in_take == '0));

  // R8: an underflow flag points at a presented lane that was not taken
  p_err_at_stall_r8: assert property (@(posedge clk) disable iff (!rst_s)
    err_underflow |-> ((in_take < CW'(LANES)) && in_valid[in_take[LIW-1:0]]));

  for (genvar g = 0; g < LANES; g++) begin : g_lane_chk
    // R4: a store carries data and no destination
    p_store_shape_r4: assert property (@(posedge clk) disable iff (!rst_s)
      (uop_valid[g] && uop_class[g*3 +: 3] == OP_STORE) |->
        (uop_src0_v[g] && !uop_src1_v[g] && !uop_dst_v[g]));
    // R2: a load has no sources and a destination
    p_load_shape_r2: assert property (@(posedge clk) disable iff (!rst_s)
      (uop_valid[g] && uop_class[g*3 +: 3] == OP_LOAD) |->
        (!uop_src0_v[g] && !uop_src1_v[g] && uop_dst_v[g]));
    // R11: only loads are ordered behind a store
    p_dep_on_load_r11: assert property (@(posedge clk) disable iff (!rst_s)
      uop_mem_dep[g] |-> (uop_valid[g] && uop_class[g*3 +: 3] == OP_LOAD));
  end

endmodule

// File: tb/sim_sx_translator.sv
module sim_sx_translator;
  localparam int LANES = 4, NREG = 32, DEPTH = 16, AW = 32;
  localparam int TW = 5, LIW = 2, CW = 3;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic                 rst_n;
  logic [LANES-1:0]     in_valid;
  logic [LANES*3-1:0]   in_op;
  logic [LANES*AW-1:0]  in_addr;
  logic [CW-1:0]        in_take;
  logic                 err_underflow;
  logic                 rel_valid;
  logic [TW-1:0]        rel_tag;
  logic                 out_valid;
  logic                 out_ready;
  logic [LANES-1:0]     uop_valid, uop_src0_v, uop_src1_v, uop_dst_v, uop_mem_dep;
  logic [LANES*3-1:0]   uop_class;
  logic [LANES*TW-1:0]  uop_src0, uop_src1, uop_dst;
  logic [LANES*AW-1:0]  uop_addr;
  logic [LANES*LIW-1:0] uop_dep_lane;

  sx_translator u0 (.*);

  int nchk = 0, nfail = 0;
  bit done = 0;

  // behavioural reference state
  int stk[$];
  bit mfree[NREG];
  bit m_ov;
  int x_v[LANES], x_cls[LANES], x_s0[LANES], x_s0v[LANES], x_s1[LANES], x_s1v[LANES];
  int x_dst[LANES], x_dstv[LANES], x_md[LANES], x_mdl[LANES];
  longint x_addr[LANES];
  int act_take, act_err;

  task automatic chk(input string tag, input longint act, input longint exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic bit on_stack(input int t);
    foreach (stk[k]) if (stk[k] == t) return 1;
    return 0;
  endfunction

  task automatic model_reset();
    stk.delete();
    for (int r = 0; r < NREG; r++) mfree[r] = 1;
    m_ov = 0;
    for (int i = 0; i < LANES; i++) begin
      x_v[i] = 0; x_cls[i] = 0; x_s0[i] = 0; x_s0v[i] = 0; x_s1[i] = 0; x_s1v[i] = 0;
      x_dst[i] = 0; x_dstv[i] = 0; x_md[i] = 0; x_mdl[i] = 0; x_addr[i] = 0;
    end
  endtask

  task automatic model_eval(output int e_take, output int e_err);
    bit adv, go, em, wd;
    int npop, npush, f, t0, t1, op;
    longint a;
    int n_v[LANES], n_cls[LANES], n_s0[LANES], n_s0v[LANES], n_s1[LANES], n_s1v[LANES];
    int n_dst[LANES], n_dstv[LANES], n_md[LANES], n_mdl[LANES], st[LANES];
    longint n_addr[LANES];
    for (int i = 0; i < LANES; i++) begin
      n_v[i] = 0; n_cls[i] = 0; n_s0[i] = 0; n_s0v[i] = 0; n_s1[i] = 0; n_s1v[i] = 0;
      n_dst[i] = 0; n_dstv[i] = 0; n_md[i] = 0; n_mdl[i] = 0; n_addr[i] = 0; st[i] = 0;
    end
    adv = !m_ov || out_ready;
    go = adv; e_take = 0; e_err = 0;
    for (int i = 0; i < LANES; i++) begin
      if (!go || !in_valid[i]) begin go = 0; continue; end
      op = int'(in_op[i*3 +: 3]);
      a  = longint'(in_addr[i*AW +: AW]);
      case (op)
        0: begin npop = 0; npush = 1; end
        1: begin npop = 1; npush = 0; end
        2: begin npop = 1; npush = 1; end
        3, 4: begin npop = 2; npush = 1; end
        5: begin npop = 1; npush = 0; end
        default: begin npop = 0; npush = 0; end
      endcase
      wd = (npush == 1);
      em = (op <= 4);
      f = -1;
      for (int r = 0; r < NREG; r++) if (mfree[r] && f < 0) f = r;
      if (npop > stk.size()) begin go = 0; e_err = 1; end
      else if (stk.size() - npop + npush > DEPTH) go = 0;
      else if (wd && f < 0) go = 0;
      else begin
        e_take++;
        t0 = 0; t1 = 0;
        if (npop == 2) begin t1 = stk.pop_back(); t0 = stk.pop_back(); end
        else if (npop == 1) t0 = stk.pop_back();
        if (wd) begin mfree[f] = 0; stk.push_back(f); end
        if (em) begin
          n_v[i] = 1; n_cls[i] = op;
          if (npop >= 1) begin n_s0[i] = (npop == 2) ? t0 : t0; n_s0v[i] = 1; end
          if (npop == 2) begin n_s1[i] = t1; n_s1v[i] = 1; end
          if (wd) begin n_dst[i] = f; n_dstv[i] = 1; end
          if (op == 0 || op == 1) n_addr[i] = a;
          if (op == 1) st[i] = 1;
          if (op == 0)
            for (int j = 0; j < i; j++)
              if (st[j] == 1 && longint'(in_addr[j*AW +: AW]) == a) begin
                n_md[i] = 1; n_mdl[i] = j;
              end
        end
      end
    end
    if (adv) begin
      m_ov = 0;
      for (int i = 0; i < LANES; i++) begin
        x_v[i] = n_v[i]; x_cls[i] = n_cls[i]; x_s0[i] = n_s0[i]; x_s0v[i] = n_s0v[i];
        x_s1[i] = n_s1[i]; x_s1v[i] = n_s1v[i]; x_dst[i] = n_dst[i]; x_dstv[i] = n_dstv[i];
        x_addr[i] = n_addr[i]; x_md[i] = n_md[i]; x_mdl[i] = n_mdl[i];
        if (n_v[i] == 1) m_ov = 1;
      end
    end
    if (rel_valid) mfree[rel_tag] = 1;
  endtask

  // one clock: inputs already driven; checks both edges of the cycle
  task automatic step();
    int et, ee;
    @(negedge clk);
    act_take = int'(in_take);
    act_err  = int'(err_underflow);
    model_eval(et, ee);
    chk("R7 in_take", act_take, et);
    chk("R8 err_underflow", act_err, ee);
    @(posedge clk);
    #1;
    chk("R12 out_valid", out_valid, m_ov);
    for (int i = 0; i < LANES; i++) begin
      chk("R13 uop_valid", uop_valid[i], x_v[i]);
      chk("R13 uop_class", uop_class[i*3 +: 3], x_cls[i]);
      chk("R3 uop_src0", uop_src0[i*TW +: TW], x_s0[i]);
      chk("R3 uop_src0_v", uop_src0_v[i], x_s0v[i]);
      chk("R3 uop_src1", uop_src1[i*TW +: TW], x_s1[i]);
      chk("R3 uop_src1_v", uop_src1_v[i], x_s1v[i]);
      chk("R2 uop_dst", uop_dst[i*TW +: TW], x_dst[i]);
      chk("R2 uop_dst_v", uop_dst_v[i], x_dstv[i]);
      chk("R13 uop_addr", uop_addr[i*AW +: AW], x_addr[i]);
      chk("R11 uop_mem_dep", uop_mem_dep[i], x_md[i]);
      chk("R11 uop_dep_lane", uop_dep_lane[i*LIW +: LIW], x_mdl[i]);
    end
    rel_valid = 0;
  endtask

  task automatic clr();
    in_valid = '0; in_op = '0; in_addr = '0;
  endtask

  task automatic lane(input int i, input int op, input longint addr);
    in_valid[i] = 1'b1;
    in_op[i*3 +: 3] = 3'(op);
    in_addr[i*AW +: AW] = AW'(addr);
  endtask

  task automatic do_reset();
    clr(); rel_valid = 0; rel_tag = '0; out_ready = 1;
    rst_n = 0;
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    repeat (3) @(posedge clk);
    #1;
  endtask

  function automatic int dst_of(input int i);
    return int'(uop_dst[i*TW +: TW]);
  endfunction

  initial begin
    #1_500_000;
    if (!done) begin
      nfail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R1: reset state
    chk("R1 out_valid after reset", out_valid, 0);
    clr(); step();
    chk("R1 in_take idle", act_take, 0);

    // R2 R3 R4 R7 R13: chained group, lowest tags first
    clr(); lane(0, 0, 'h100); lane(1, 0, 'h104); lane(2, 3, 'hdead); lane(3, 1, 'h108);
    step();
    chk("R7 take full group", act_take, 4);
    chk("R2 load lane0 dst", dst_of(0), 0);
    chk("R2 load lane1 dst", dst_of(1), 1);
    chk("R3 add src0 second", uop_src0[2*TW +: TW], 0);
    chk("R3 add src1 top", uop_src1[2*TW +: TW], 1);
    chk("R3 add dst", dst_of(2), 2);
    chk("R4 store src0", uop_src0[3*TW +: TW], 2);
    chk("R4 store no dst", uop_dst_v[3], 0);
    chk("R4 store addr", uop_addr[3*AW +: AW], 'h108);
    chk("R13 alu addr zero", uop_addr[2*AW +: AW], 0);

    // R10: release returns registers
    clr(); rel_valid = 1; rel_tag = 0; step();
    clr(); rel_valid = 1; rel_tag = 1; step();
    clr(); lane(0, 0, 'h200); step();
    chk("R10 released tag reused", dst_of(0), 0);
    // R5: negate replaces top
    clr(); lane(0, 2, 0); step();
    chk("R5 neg src0", uop_src0[TW-1:0], 0);
    chk("R5 neg dst", dst_of(0), 1);
    // R6: pop and spare codes emit nothing
    clr(); lane(0, 5, 0); step();
    chk("R6 pop taken", act_take, 1);
    chk("R6 pop no out_valid", out_valid, 0);
    clr(); lane(0, 6, 0); lane(1, 7, 0); step();
    chk("R6 spare codes taken", act_take, 2);
    chk("R6 spare codes no out_valid", out_valid, 0);
    // R8: underflow on empty stack
    clr(); lane(0, 2, 0); step();
    chk("R8 neg on empty take", act_take, 0);
    chk("R8 neg on empty err", act_err, 1);
    clr(); lane(0, 0, 'h300); lane(1, 4, 0); lane(2, 0, 'h304); step();
    chk("R8 partial take", act_take, 1);
    chk("R8 partial err", act_err, 1);
    chk("R8 lane0 dst", dst_of(0), 3);
    chk("R8 later lane idle", uop_valid[2], 0);

    // R11: load behind the nearest earlier store
    clr(); lane(0, 1, 'h40); lane(1, 0, 'h40); lane(2, 1, 'h40); lane(3, 0, 'h40); step();
    chk("R11 lane1 dep", uop_mem_dep[1], 1);
    chk("R11 lane1 dep lane", uop_dep_lane[1*LIW +: LIW], 0);
    chk("R11 lane3 dep lane nearest", uop_dep_lane[3*LIW +: LIW], 2);
    chk("R11 lane3 dst", dst_of(3), 5);
    clr(); lane(0, 1, 'h80); lane(1, 0, 'h84); step();
    chk("R11 different addr no dep", uop_mem_dep[1], 0);

    // R12: back-pressure
    clr(); lane(0, 0, 'h500); out_ready = 0; step();
    chk("R12 blocked take", act_take, 0);
    chk("R12 held dst", dst_of(1), 6);
    out_ready = 1; step();
    chk("R12 resumed take", act_take, 1);
    chk("R12 resumed dst", dst_of(0), 7);
    // R7: a gap in in_valid ends the group
    clr(); lane(0, 0, 0); lane(1, 0, 0); lane(3, 0, 0); step();
    chk("R7 gap take", act_take, 2);
    chk("R7 gap lane3 idle", uop_valid[3], 0);

    // R9: depth limit
    do_reset();
    for (int g = 0; g < 4; g++) begin
      clr(); for (int i = 0; i < LANES; i++) lane(i, 0, g * 16 + i * 4); step();
    end
    clr(); lane(0, 0, 0); step();
    chk("R9 full stack take", act_take, 0);
    chk("R9 full stack no err", act_err, 0);
    clr(); lane(0, 5, 0); lane(1, 0, 0); step();
    chk("R9 pop then load take", act_take, 2);
    chk("R9 pop then load dst", dst_of(1), 16);

    // R10: pool exhaustion
    do_reset();
    for (int g = 0; g < 16; g++) begin
      clr(); lane(0, 0, 0); lane(1, 5, 0); lane(2, 0, 0); lane(3, 5, 0); step();
    end
    clr(); lane(0, 0, 0); step();
    chk("R10 no free take", act_take, 0);
    chk("R10 no free no err", act_err, 0);
    rel_valid = 1; rel_tag = 7; step();
    chk("R10 release not same cycle", act_take, 0);
    step();
    chk("R10 after release take", act_take, 1);
    chk("R10 after release dst", dst_of(0), 7);

    // random traffic against the model
    do_reset();
    for (int c = 0; c < 3000; c++) begin
      int r;
      if (c % 1000 == 999) do_reset();
      clr();
      out_ready = ($urandom % 4) != 0;
      for (int i = 0; i < LANES; i++) begin
        r = $urandom % 10;
        in_valid[i] = ($urandom % 6) != 0;
        in_op[i*3 +: 3] = (r < 4) ? 3'd0 : (r == 4) ? 3'd1 : (r == 5) ? 3'd2 :
                          (r == 6) ? 3'd3 : (r == 7) ? 3'd4 : (r == 8) ? 3'd5 :
                          3'(6 + ($urandom % 2));
        in_addr[i*AW +: AW] = AW'(($urandom % 4) * 4);
      end
      if ($urandom % 3 == 0) begin
        for (int k = 0; k < 8; k++) begin
          int t;
          t = $urandom % NREG;
          if (!rel_valid && !mfree[t] && !on_stack(t)) begin
            rel_valid = 1; rel_tag = TW'(t);
          end
        end
      end
      step();
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

endmodule